// File: doc/BRIEF.md
# Carrier Lock Detector Controller

This block judges whether a carrier tracking loop has achieved phase lock. Each accepted input beat carries a signed phase error and a signed false-lock metric. Three 16-bit registers run side by side: an integration counter that advances by one per beat, a phase accumulator that adds the magnitude of the phase error, and a false-lock accumulator that adds the magnitude of the metric. Every register is loaded with a host-programmed preload when an integration period begins. The period ends on the beat whose counter increment carries out. Lock decisions come from a race: whichever register carries first within a period decides the outcome.

A four-state controller moves the loop through search, verify, false-lock escape and locked. It drives the loop parameter select (acquisition or tracking), the frequency sweep enable and the lock status. The loop filter, the oscillator and the sweep generator are outside this block.

A manual mode hands control to a host. In this mode the controller is held in search and the three outputs follow host bits. At the end of each period the accumulators freeze for reading and an interrupt pulses. Input beats are back-pressured until the host restarts the period.

Input beats use a valid/ready handshake. A beat transfers in a cycle where both `in_valid` and `in_ready` are high. While `in_ready` is low, the source must hold its beat and the block takes nothing. `in_ready` is low for one preload cycle at each period start, and stays low for as long as a manual-mode period is frozen.

Top module: `carrier_lock_ctrl`

## Requirements
- R1: While reset is asserted, `in_ready` is 0. After reset, `state_o` is 0 (search), `sweep_en` is 1, `loop_trk_sel` is 0, `lock_o` is 0 and `lk_int` is 0. `in_ready` rises after one preload cycle.
- R2: A beat is consumed only when `in_valid` and `in_ready` are both high. While a manual-mode period is frozen, offered beats leave `pe_acc_o` and `fl_acc_o` unchanged.
- R3: Each consumed beat adds 1 to the integration counter, |phase error| to the phase accumulator and |metric| to the false-lock accumulator, all modulo 2^16. At each period start, the counter and the phase accumulator load the acquisition or tracking preload chosen by `loop_trk_sel`. The period ends on the beat whose counter increment carries out of bit 15.
- R4: In search (`state_o`=0), a period passes when the phase accumulator produced no carry on any of its beats. A carry on the final beat also counts as a failure. A passing period moves the controller to verify (`state_o`=1). A failing period leaves it in search.
- R5: In verify, `loop_trk_sel`=1 and `sweep_en`=0. The controller enters lock (`state_o`=3) after N consecutive passing verify periods, where N is `cfg_wdata[7:0]` at address 5 and a value of 0 acts as 1. A failing period returns it to search.
- R6: In verify, a false-lock accumulator carry on any beat of the period, including the last, moves the controller to false-lock (`state_o`=2). This takes priority over the pass/fail result of the same period.
- R7: In false-lock, `sweep_en`=1 and `loop_trk_sel`=0. After D periods the controller returns to search, where D is bits [15:8] at address 5 and 0 acts as 1.
- R8: In lock, `lock_o`=1 and `loop_trk_sel`=1. The controller stays in lock while periods pass, ignores the false-lock metric, and returns to search on a failing period.
- R9: The host registers are at these addresses: 0 acquisition counter preload, 1 tracking counter preload, 2 acquisition phase preload, 3 tracking phase preload, 4 false-lock preload, 5 counts, 6 control. A preload written in mid-period takes effect only at the next period start.
- R10: Setting control bit 0 selects manual mode. The controller is held in search. `loop_trk_sel`, `sweep_en` and `lock_o` follow control bits 1, 2 and 3. At each period end the accumulators and their sticky carry flags (`pe_ovf_o`, `fl_ovf_o`) hold, `in_ready` drops, and `lk_int` is high for exactly the one cycle after the final beat.
- R11: A `host_restart` pulse while frozen, or any write to the control address, begins a new period. The accumulators reload with their preloads and `in_ready` returns after one preload cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_phase_err | input | 8 | Signed phase error sample |
| in_flk_err | input | 8 | Signed false-lock metric sample |
| cfg_we | input | 1 | Host register write strobe |
| cfg_addr | input | 3 | Host register address |
| cfg_wdata | input | 16 | Host write data |
| host_restart | input | 1 | Restart a frozen manual period |
| loop_trk_sel | output | 1 | 1 selects tracking loop parameters |
| sweep_en | output | 1 | Frequency sweep enable |
| lock_o | output | 1 | Lock status |
| state_o | output | 2 | Controller state, 0 search, 1 verify, 2 false-lock, 3 lock |
| lk_int | output | 1 | Period-complete interrupt pulse (manual mode) |
| pe_acc_o | output | 16 | Phase accumulator value |
| fl_acc_o | output | 16 | False-lock accumulator value |
| pe_ovf_o | output | 1 | Phase accumulator carried in this period |
| fl_ovf_o | output | 1 | False-lock accumulator carried in this period |

## Verification
Two pairs of events can fall on the same beat. The first pair is the period-closing counter carry and a carry from the phase or false-lock accumulator. The bench provokes this with beat magnitudes that sum exactly to the remaining headroom, so the carry lands on the last beat, and expects the accumulator to win. The second pair is a passing phase result and a false-lock hit in one verify period. The bench provokes this with a low phase total and a false-lock total at its limit, and expects the false-lock state to win. Randomized periods then mix both totals around their limits and compare every state transition against a bench model of the controller.

// File: rtl/cld_pkg.sv
package cld_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_VERIFY = 2'd1,
    ST_FLOCK  = 2'd2,
    ST_LOCKED = 2'd3
  } cld_state_e;

  localparam int unsigned REG_INT_ACQ = 0;
  localparam int unsigned REG_INT_TRK = 1;
  localparam int unsigned REG_PE_ACQ  = 2;
  localparam int unsigned REG_PE_TRK  = 3;
  localparam int unsigned REG_FL_PRE  = 4;
  localparam int unsigned REG_COUNTS  = 5;
  localparam int unsigned REG_CTRL    = 6;

  localparam int unsigned CTRL_MANUAL = 0;
  localparam int unsigned CTRL_TRK    = 1;
  localparam int unsigned CTRL_SWEEP  = 2;
  localparam int unsigned CTRL_LOCK   = 3;
endpackage

// File: rtl/cld_cfg_bank.sv
module cld_cfg_bank #(
  parameter int ACC_W  = 16,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ACC_W-1:0]  wdata,
  output logic [ACC_W-1:0]  int_acq,
  output logic [ACC_W-1:0]  int_trk,
  output logic [ACC_W-1:0]  pe_acq,
  output logic [ACC_W-1:0]  pe_trk,
  output logic [ACC_W-1:0]  fl_pre,
  output logic [CNT_W-1:0]  verify_tgt,
  output logic [CNT_W-1:0]  dwell_tgt,
  output logic              manual,
  output logic              h_trk,
  output logic              h_sweep,
  output logic              h_lock,
  output logic              ctrl_wr
);
  import cld_pkg::*;

  localparam logic [ACC_W-1:0] ONES       = {ACC_W{1'b1}};
  localparam logic [ACC_W-1:0] RST_INT    = ONES << 4;
  localparam logic [ACC_W-1:0] RST_PE_ACQ = ONES << 8;
  localparam logic [ACC_W-1:0] RST_PE_TRK = ONES << 7;
  localparam logic [ACC_W-1:0] RST_FL     = ONES << 8;
  localparam logic [CNT_W-1:0] RST_VER    = CNT_W'(3);
  localparam logic [CNT_W-1:0] RST_DWELL  = CNT_W'(2);

  assign ctrl_wr = we && (addr == ADDR_W'(REG_CTRL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_acq    <= RST_INT;
      int_trk    <= RST_INT;
      pe_acq     <= RST_PE_ACQ;
      pe_trk     <= RST_PE_TRK;
      fl_pre     <= RST_FL;
      verify_tgt <= RST_VER;
      dwell_tgt  <= RST_DWELL;
      manual     <= 1'b0;
      h_trk      <= 1'b0;
      h_sweep    <= 1'b0;
      h_lock     <= 1'b0;
    end else if (we) begin
      case (addr)
        ADDR_W'(REG_INT_ACQ): int_acq <= wdata;
        ADDR_W'(REG_INT_TRK): int_trk <= wdata;
        ADDR_W'(REG_PE_ACQ):  pe_acq  <= wdata;
        ADDR_W'(REG_PE_TRK):  pe_trk  <= wdata;
        ADDR_W'(REG_FL_PRE):  fl_pre  <= wdata;
        ADDR_W'(REG_COUNTS): begin
          verify_tgt <= wdata[CNT_W-1:0];
          dwell_tgt  <= wdata[2*CNT_W-1:CNT_W];
        end
        ADDR_W'(REG_CTRL): begin
          manual  <= wdata[CTRL_MANUAL];
          h_trk   <= wdata[CTRL_TRK];
          h_sweep <= wdata[CTRL_SWEEP];
          h_lock  <= wdata[CTRL_LOCK];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cld_accum.sv
module cld_accum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic [W-1:0] inc,
  output logic [W-1:0] acc,
  output logic         carry_now,
  output logic         ovf_seen
);
  logic [W:0] sum;

  assign sum       = {1'b0, acc} + {1'b0, inc};
  assign carry_now = step & sum[W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      ovf_seen <= 1'b0;
    end else if (load) begin
      acc      <= load_val;
      ovf_seen <= 1'b0;
    end else if (step) begin
      acc      <= sum[W-1:0];
      ovf_seen <= ovf_seen | sum[W];
    end
  end
endmodule

// File: rtl/cld_fsm.sv
module cld_fsm #(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              manual,
  input  logic              period_end,
  input  logic              pe_fail,
  input  logic              fl_hit,
  input  logic [CNT_W-1:0]  verify_tgt,
  input  logic [CNT_W-1:0]  dwell_tgt,
  output cld_pkg::cld_state_e state
);
  import cld_pkg::*;

  logic [CNT_W-1:0] vcnt, dcnt;
  logic [CNT_W:0]   vnext, dnext, vtgt_eff, dtgt_eff;

  assign vnext    = {1'b0, vcnt} + 1'b1;
  assign dnext    = {1'b0, dcnt} + 1'b1;
  assign vtgt_eff = (verify_tgt == '0) ? (CNT_W+1)'(1) : {1'b0, verify_tgt};
  assign dtgt_eff = (dwell_tgt == '0) ? (CNT_W+1)'(1) : {1'b0, dwell_tgt};

  always_ff @(posedge clk) begin
    if (!rst_n || manual) begin
      state <= ST_SEARCH;
      vcnt  <= '0;
      dcnt  <= '0;
    end else if (period_end) begin
      case (state)
        ST_SEARCH: begin
          if (!pe_fail) begin
            state <= ST_VERIFY;
            vcnt  <= '0;
          end
        end
        ST_VERIFY: begin
          if (fl_hit) begin
            state <= ST_FLOCK;
            dcnt  <= '0;
          end else if (pe_fail) begin
            state <= ST_SEARCH;
          end else if (vnext >= vtgt_eff) begin
            state <= ST_LOCKED;
          end else begin
            vcnt <= vnext[CNT_W-1:0];
          end
        end
        ST_FLOCK: begin
          if (dnext >= dtgt_eff) state <= ST_SEARCH;
          else dcnt <= dnext[CNT_W-1:0];
        end
        ST_LOCKED: begin
          if (pe_fail) state <= ST_SEARCH;
        end
        default: state <= ST_SEARCH;
      endcase
    end
  end
endmodule

// File: rtl/carrier_lock_ctrl.sv
module carrier_lock_ctrl #(
  parameter int PE_W   = 8,
  parameter int ACC_W  = 16,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PE_W-1:0]   in_phase_err,
  input  logic [PE_W-1:0]   in_flk_err,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [ACC_W-1:0]  cfg_wdata,
  input  logic              host_restart,
  output logic              loop_trk_sel,
  output logic              sweep_en,
  output logic              lock_o,
  output logic [1:0]        state_o,
  output logic              lk_int,
  output logic [ACC_W-1:0]  pe_acc_o,
  output logic [ACC_W-1:0]  fl_acc_o,
  output logic              pe_ovf_o,
  output logic              fl_ovf_o
);
  import cld_pkg::*;

  localparam int NACC    = 3;
  localparam int IDX_INT = 0;
  localparam int IDX_PE  = 1;
  localparam int IDX_FL  = 2;
  localparam int PAD_W   = ACC_W - PE_W;

  logic [ACC_W-1:0] int_acq, int_trk, pe_acq, pe_trk, fl_pre;
  logic [CNT_W-1:0] verify_tgt, dwell_tgt;
  logic             cfg_manual, h_trk, h_sweep, h_lock, ctrl_wr;

  cld_cfg_bank #(.ACC_W(ACC_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .int_acq(int_acq), .int_trk(int_trk), .pe_acq(pe_acq), .pe_trk(pe_trk),
    .fl_pre(fl_pre), .verify_tgt(verify_tgt), .dwell_tgt(dwell_tgt),
    .manual(cfg_manual), .h_trk(h_trk), .h_sweep(h_sweep), .h_lock(h_lock),
    .ctrl_wr(ctrl_wr)
  );

  logic       start_pend, halted, accept, period_end, pe_fail, fl_hit, auto_trk;
  cld_state_e state;

  logic [PE_W-1:0]  pe_mag, fl_mag;
  logic [ACC_W-1:0] ld_val  [NACC];
  logic [ACC_W-1:0] inc_val [NACC];
  logic [ACC_W-1:0] acc_val [NACC];
  logic [NACC-1:0]  carry_now, ovf_seen;

  assign in_ready = !start_pend && !halted;
  assign accept   = in_valid && in_ready;

  // magnitudes: the most negative code maps to its unsigned magnitude
  assign pe_mag = in_phase_err[PE_W-1] ? (~in_phase_err + 1'b1) : in_phase_err;
  assign fl_mag = in_flk_err[PE_W-1]   ? (~in_flk_err + 1'b1)   : in_flk_err;

  assign auto_trk     = (state == ST_VERIFY) || (state == ST_LOCKED);
  assign loop_trk_sel = cfg_manual ? h_trk   : auto_trk;
  assign sweep_en     = cfg_manual ? h_sweep : ((state == ST_SEARCH) || (state == ST_FLOCK));
  assign lock_o       = cfg_manual ? h_lock  : (state == ST_LOCKED);
  assign state_o      = state;

  assign ld_val[IDX_INT]  = loop_trk_sel ? int_trk : int_acq;
  assign ld_val[IDX_PE]   = loop_trk_sel ? pe_trk  : pe_acq;
  assign ld_val[IDX_FL]   = fl_pre;
  assign inc_val[IDX_INT] = ACC_W'(1);
  assign inc_val[IDX_PE]  = {{PAD_W{1'b0}}, pe_mag};
  assign inc_val[IDX_FL]  = {{PAD_W{1'b0}}, fl_mag};

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    cld_accum #(.W(ACC_W)) acc_i (
      .clk(clk), .rst_n(rst_n), .load(start_pend), .load_val(ld_val[g]),
      .step(accept), .inc(inc_val[g]), .acc(acc_val[g]),
      .carry_now(carry_now[g]), .ovf_seen(ovf_seen[g])
    );
  end

  // a carry on the closing beat counts against the loop (tie rule)
  assign period_end = carry_now[IDX_INT];
  assign pe_fail    = ovf_seen[IDX_PE] | carry_now[IDX_PE];
  assign fl_hit     = ovf_seen[IDX_FL] | carry_now[IDX_FL];

  cld_fsm #(.CNT_W(CNT_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .manual(cfg_manual), .period_end(period_end),
    .pe_fail(pe_fail), .fl_hit(fl_hit), .verify_tgt(verify_tgt),
    .dwell_tgt(dwell_tgt), .state(state)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_pend <= 1'b1;
      halted     <= 1'b0;
      lk_int     <= 1'b0;
    end else begin
      lk_int <= period_end && cfg_manual;
      if (ctrl_wr) begin
        start_pend <= 1'b1;
        halted     <= 1'b0;
      end else if (start_pend) begin
        start_pend <= 1'b0;
      end else if (period_end) begin
        if (cfg_manual) halted <= 1'b1;
        else start_pend <= 1'b1;
      end else if (halted && host_restart) begin
        halted     <= 1'b0;
        start_pend <= 1'b1;
      end
    end
  end

  assign pe_acc_o = acc_val[IDX_PE];
  assign fl_acc_o = acc_val[IDX_FL];
  assign pe_ovf_o = ovf_seen[IDX_PE];
  assign fl_ovf_o = ovf_seen[IDX_FL];
endmodule

// File: rtl/cld_checker.sv
module cld_checker #(
  parameter int ACC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       state_o,
  input logic             in_ready,
  input logic             lk_int,
  input logic [ACC_W-1:0] pe_acc_o,
  input logic             manual
);
  // R10
  int_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_int |=> !lk_int);

  // R5
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_o == 2'd3) |-> $past(state_o) == 2'd1);

  // R6
  flock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_o == 2'd2) |-> $past(state_o) == 2'd1);

  // R7
  flock_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == 2'd2 && state_o != 2'd2) |-> state_o == 2'd0);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && $past(!in_ready)) |-> $stable(pe_acc_o));

  // R10
  manual_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (manual && $past(manual)) |-> state_o == 2'd0);
endmodule

bind carrier_lock_ctrl cld_checker #(.ACC_W(ACC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .state_o(state_o), .in_ready(in_ready),
  .lk_int(lk_int), .pe_acc_o(pe_acc_o), .manual(cfg_manual)
);

// File: tb/carrier_lock_ctrl_tb_top.sv
module carrier_lock_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_phase_err = '0, in_flk_err = '0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic host_restart = 1'b0;
  logic loop_trk_sel, sweep_en, lock_o, lk_int, pe_ovf_o, fl_ovf_o;
  logic [1:0] state_o;
  logic [15:0] pe_acc_o, fl_acc_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  carrier_lock_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_phase_err(in_phase_err), .in_flk_err(in_flk_err), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .host_restart(host_restart),
    .loop_trk_sel(loop_trk_sel), .sweep_en(sweep_en), .lock_o(lock_o),
    .state_o(state_o), .lk_int(lk_int), .pe_acc_o(pe_acc_o),
    .fl_acc_o(fl_acc_o), .pe_ovf_o(pe_ovf_o), .fl_ovf_o(fl_ovf_o)
  );

  int n_chk = 0, n_bad = 0;
  int m_state = 0, m_vcnt = 0, m_dcnt = 0;
  int vtgt = 3, dwell = 2;
  bit gaps = 1'b0;

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic cfg_write(int addr, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // called at a negedge; returns at the negedge after the beat is taken
  task automatic send(int pe, int fl);
    if (gaps && ($urandom % 4 == 0)) @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_phase_err = 8'(pe); in_flk_err = 8'(fl);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic int sgn(int mag);
    return ($urandom % 2 == 1) ? -mag : mag;
  endfunction

  task automatic send_even(int n, int pe_tot, int fl_tot);
    for (int i = 0; i < n; i++) begin
      int pm = (i == n-1) ? pe_tot - (n-1)*(pe_tot/n) : pe_tot/n;
      int fm = (i == n-1) ? fl_tot - (n-1)*(fl_tot/n) : fl_tot/n;
      send(sgn(pm), sgn(fm));
    end
  endtask

  function automatic bit exp_trk(int st);
    return (st == 1 || st == 3);
  endfunction

  // one auto-mode period of 16 beats, model update and output checks
  task automatic run_period(int pe_tot, int fl_tot);
    int budget = exp_trk(m_state) ? 128 : 256;
    bit pass = (pe_tot < budget);
    bit flh = (fl_tot >= 256);
    string req;
    send_even(16, pe_tot, fl_tot);
    case (m_state)
      0: begin req = "R4"; if (pass) begin m_state = 1; m_vcnt = 0; end end
      1: begin
        req = flh ? "R6" : "R5";
        if (flh) begin m_state = 2; m_dcnt = 0; end
        else if (!pass) m_state = 0;
        else if (m_vcnt + 1 >= (vtgt == 0 ? 1 : vtgt)) m_state = 3;
        else m_vcnt++;
      end
      2: begin
        req = "R7";
        if (m_dcnt + 1 >= (dwell == 0 ? 1 : dwell)) m_state = 0; else m_dcnt++;
      end
      default: begin req = "R8"; if (!pass) m_state = 0; end
    endcase
    check(req, "state_o", int'(state_o), m_state);
    check(req, "lock_o", int'(lock_o), int'(m_state == 3));
    check(req, "sweep_en", int'(sweep_en), int'(m_state == 0 || m_state == 2));
    check(req, "loop_trk_sel", int'(loop_trk_sel), int'(exp_trk(m_state)));
  endtask

  initial begin
    int unsigned seed_set = $urandom(32'd1234);
    if (seed_set == 0) gaps = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "in_ready in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "state_o", int'(state_o), 0);
    check("R1", "sweep_en", int'(sweep_en), 1);
    check("R1", "loop_trk_sel", int'(loop_trk_sel), 0);
    check("R1", "lock_o", int'(lock_o), 0);
    check("R1", "lk_int", int'(lk_int), 0);
    check("R1", "in_ready", int'(in_ready), 1);

    // R4: search fail, tie on the last beat, then pass
    run_period(320, 0);
    run_period(256, 0);
    run_period(255, 0);
    // R5: three passing verify periods reach lock
    run_period(100, 0);
    run_period(100, 0);
    run_period(100, 0);
    // R8: metric ignored in lock, tie on tracking budget drops lock
    run_period(100, 300);
    run_period(128, 0);
    // R6: false-lock tie beats a passing phase result; R7 dwell of two
    run_period(200, 0);
    run_period(50, 256);
    run_period(0, 0);
    run_period(0, 0);
    // R5: verify failure
    run_period(10, 0);
    run_period(130, 0);
    // R9: count fields at address 5
    cfg_write(5, 16'h0101); vtgt = 1; dwell = 1;
    run_period(10, 0);
    run_period(10, 0);
    check("R9", "verify count field", int'(state_o), 3);
    run_period(300, 0);
    cfg_write(5, 16'h0203); vtgt = 3; dwell = 2;

    // randomized periods around the limits
    gaps = 1'b1;
    for (int k = 0; k < 60; k++) begin
      int pt = ($urandom % 2 == 1) ? int'($urandom_range(0, 127)) : int'($urandom_range(100, 400));
      int ft = ($urandom % 3 == 0) ? int'($urandom_range(240, 400)) : int'($urandom_range(0, 200));
      run_period(pt, ft);
    end
    gaps = 1'b0;

    // R10: manual mode with tracking select from host bit
    cfg_write(6, 16'h0003);
    @(negedge clk);
    check("R10", "state held in search", int'(state_o), 0);
    check("R10", "host trk bit", int'(loop_trk_sel), 1);
    check("R10", "host sweep bit", int'(sweep_en), 0);
    check("R10", "host lock bit", int'(lock_o), 0);
    for (int i = 0; i < 16; i++) send(sgn(5), sgn(3));
    check("R10", "lk_int after period", int'(lk_int), 1);
    check("R10", "in_ready frozen", int'(in_ready), 0);
    check("R3", "pe_acc", int'(pe_acc_o), 16'hFFD0);
    check("R3", "fl_acc", int'(fl_acc_o), 16'hFF30);
    check("R10", "pe_ovf", int'(pe_ovf_o), 0);
    @(negedge clk);
    check("R10", "lk_int one cycle", int'(lk_int), 0);
    // R2: beats offered while frozen are ignored
    in_valid = 1'b1; in_phase_err = 8'd50; in_flk_err = 8'd50;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    check("R2", "pe_acc held", int'(pe_acc_o), 16'hFFD0);
    check("R2", "fl_acc held", int'(fl_acc_o), 16'hFF30);
    // R11: restart
    host_restart = 1'b1; @(negedge clk); host_restart = 1'b0;
    check("R11", "preload cycle ready", int'(in_ready), 0);
    @(negedge clk);
    check("R11", "ready after restart", int'(in_ready), 1);
    check("R11", "pe_acc reloaded", int'(pe_acc_o), 16'hFF80);
    // R9: mid-period preload write does not shorten this period
    for (int i = 0; i < 4; i++) send(20, 0);
    cfg_write(1, 16'hFFF8);
    for (int i = 0; i < 4; i++) send(0, 0);
    check("R9", "no early end lk_int", int'(lk_int), 0);
    check("R9", "no early end ready", int'(in_ready), 1);
    for (int i = 0; i < 8; i++) send(0, 0);
    check("R9", "end after 16 beats", int'(lk_int), 1);
    check("R9", "pe_acc", int'(pe_acc_o), 16'hFFD0);
    host_restart = 1'b1; @(negedge clk); host_restart = 1'b0;
    for (int i = 0; i < 8; i++) send(20, 0);
    check("R9", "new length 8 beats", int'(lk_int), 1);
    check("R3", "pe_acc wraps", int'(pe_acc_o), 16'h0020);
    check("R10", "pe_ovf sticky", int'(pe_ovf_o), 1);
    // R10: lock and sweep from host bits
    cfg_write(6, 16'h000D);
    check("R10", "host lock", int'(lock_o), 1);
    check("R10", "host sweep", int'(sweep_en), 1);
    check("R10", "host trk", int'(loop_trk_sel), 0);
    // back to automatic control
    cfg_write(6, 16'h0000);
    @(negedge clk);
    check("R1", "auto search state", int'(state_o), 0);
    check("R1", "auto sweep", int'(sweep_en), 1);
    check("R11", "ready after ctrl write", int'(in_ready), 1);

    summary();
    $finish;
  end
endmodule